// File: doc/BRIEF.md
# Partial Configuration Image Loader

This block moves one configuration image from byte-addressed storage into a byte-wide parallel configuration port. A request names a tile (0 to 8) and chooses between two image sets: the intact set, used to repair a tile, and a deliberately corrupted set, used to inject faults. A separate full-image mode reloads the whole device image, which covers blind scrubbing of the static logic. The start address and byte length of each image come from parameter tables. The defaults place the full image at 0x400, 0x947A5C bytes long. The intact images follow it, with tile 0 at 0x948000 (0xC1530 bytes) and tile 1 at 0xA09600 (0xAF2B0 bytes). The corrupted set begins with tile 0 at 0x1B17E00.

When a load is accepted, the loader issues sequential read requests over a valid/ready channel. Returned bytes arrive in order, and each one is passed straight to the configuration port with a select and a write strobe. After the last byte, the loader watches the device's done line. A change of level in either direction within the programmed window reports success. If the window runs out with no change, an error is reported.

Top module: `pbit_fetch_loader`

## Requirements
- R1: With full mode low and the intact set chosen, a start for tile k issues read requests from the tile's intact base address, and exactly its intact length of bytes reaches the configuration port.
- R2: With the corrupted set chosen (bad_set=1), the corrupted base address and length of the tile are used instead.
- R3: With full mode high, the full-image base and length are used, whatever the tile and set inputs hold.
- R4: A request address is held stable while the request is stalled. Each accepted request is followed by the next higher address, and no request is issued once the byte count is used up.
- R5: cfg_sel is high for the whole transfer phase. cfg_wr is high only in a transfer cycle where a returned byte is valid, and cfg_data then equals that stored byte, in address order.
- R6: After the last byte, a change of cfg_done in either direction sets load_ok, and busy falls on the same edge.
- R7: If cfg_done does not change during the done_timeout+1 cycles that follow the last byte, load_err is set and busy falls.
- R8: A change of cfg_done in the final cycle of the window still counts as success and not as an error.
- R9: busy rises on the edge after an accepted start and stays high until success or error. load_ok and load_err clear on an accepted start, are never set together, and otherwise hold.
- R10: A start is ignored while busy. A start with tile_sel of 9 or more and full mode low is also ignored.
- R11: A change of cfg_done during the transfer phase is not taken as completion.
- R12: After reset the block is idle: busy, rd_valid, cfg_sel, cfg_wr, load_ok and load_err are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load request, sampled while idle |
| full_mode | input | 1 | 1: load the full device image |
| bad_set | input | 1 | 1: use the corrupted image set |
| tile_sel | input | 4 | Tile index, 0 to 8 |
| done_timeout | input | 16 | Done window length minus one, in cycles |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | 32 | Read request byte address |
| rd_ready | input | 1 | Storage accepts the request |
| rsp_valid | input | 1 | Returned byte valid, in request order |
| rsp_data | input | 8 | Returned byte |
| cfg_sel | output | 1 | Configuration port select, high during transfer |
| cfg_wr | output | 1 | Configuration write strobe |
| cfg_data | output | 8 | Configuration byte |
| cfg_done | input | 1 | Device done line, watched for a change |
| busy | output | 1 | Load in progress |
| load_ok | output | 1 | Last load confirmed |
| load_err | output | 1 | Last load timed out |

## Verification
Two events can meet in one cycle: the done line can change on the very cycle the window counter reaches its limit, and the loader must then report success. The bench provokes this by changing cfg_done exactly done_timeout cycles after the first cycle of the wait phase. A second load changes it one cycle later, and that load must end in error. A second coincidence is a request acceptance and a byte return landing in the same cycle under random ready and return gaps. A behavioural reference model compares both counters, the addresses and every written byte on every clock.

// File: rtl/pbit_fetch_loader.sv
module pbit_fetch_loader #(
  parameter int AW    = 32,
  parameter int LW    = 32,
  parameter int TILES = 9,
  parameter int TW    = $clog2(TILES),
  parameter int TOW   = 16,
  parameter logic [AW-1:0] FULL_BASE = 32'h0000_0400,
  parameter logic [LW-1:0] FULL_LEN  = 32'h0094_7A5C,
  parameter logic [TILES*AW-1:0] GOOD_BASE = {
    32'h00ED4200, 32'h00E24E00, 32'h00D75A00, 32'h00CC6600, 32'h00C17200,
    32'h00B67E00, 32'h00AB8A00, 32'h00A09600, 32'h00948000},
  parameter logic [TILES*LW-1:0] GOOD_LEN = {{8{32'h000AF2B0}}, 32'h000C1530},
  parameter logic [TILES*AW-1:0] BAD_BASE = {
    32'h02122E00, 32'h02061800, 32'h01FA0200, 32'h01EDEC00, 32'h01E1D600,
    32'h01D5C000, 32'h01C9AA00, 32'h01BD9400, 32'h01B17E00},
  parameter logic [TILES*LW-1:0] BAD_LEN = {{8{32'h000AF2B0}}, 32'h000C1530}
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           full_mode,
  input  logic           bad_set,
  input  logic [TW-1:0]  tile_sel,
  input  logic [TOW-1:0] done_timeout,
  output logic           rd_valid,
  output logic [AW-1:0]  rd_addr,
  input  logic           rd_ready,
  input  logic           rsp_valid,
  input  logic [7:0]     rsp_data,
  output logic           cfg_sel,
  output logic           cfg_wr,
  output logic [7:0]     cfg_data,
  input  logic           cfg_done,
  output logic           busy,
  output logic           load_ok,
  output logic           load_err
);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_WAIT} st_t;

  st_t            state;
  logic [AW-1:0]  addr;
  logic [LW-1:0]  req_left, rsp_left;
  logic [TOW-1:0] tmr;
  logic           ok, err, done_q;
  logic [AW-1:0]  sel_base;
  logic [LW-1:0]  sel_len;

  wire tile_in = 32'(tile_sel) < TILES;
  wire accept  = (state == S_IDLE) && start && (full_mode || tile_in);
  wire toggled = cfg_done ^ done_q;

  always_comb begin
    sel_base = FULL_BASE;
    sel_len  = FULL_LEN;
    if (!full_mode)
      for (int k = 0; k < TILES; k++)
        if (32'(tile_sel) == k) begin
          sel_base = bad_set ? BAD_BASE[k*AW +: AW] : GOOD_BASE[k*AW +: AW];
          sel_len  = bad_set ? BAD_LEN[k*LW +: LW]  : GOOD_LEN[k*LW +: LW];
        end
  end

  assign busy     = state != S_IDLE;
  assign rd_valid = (state == S_XFER) && (req_left != '0);
  assign rd_addr  = addr;
  assign cfg_sel  = state == S_XFER;
  assign cfg_wr   = cfg_sel && rsp_valid;
  assign cfg_data = rsp_data;
  assign load_ok  = ok;
  assign load_err = err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      addr     <= '0;
      req_left <= '0;
      rsp_left <= '0;
      tmr      <= '0;
      ok       <= 1'b0;
      err      <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= cfg_done;
      unique case (state)
        S_IDLE: if (accept) begin
          addr     <= sel_base;
          req_left <= sel_len;
          rsp_left <= sel_len;
          tmr      <= '0;
          ok       <= 1'b0;
          err      <= 1'b0;
          state    <= (sel_len == '0) ? S_WAIT : S_XFER;
        end
        S_XFER: begin
          if (rd_valid && rd_ready) begin
            addr     <= addr + 1'b1;
            req_left <= req_left - 1'b1;
          end
          if (rsp_valid) begin
            rsp_left <= rsp_left - 1'b1;
            if (rsp_left == LW'(1)) state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (toggled) begin
            ok    <= 1'b1;
            state <= S_IDLE;
          end else if (tmr == done_timeout) begin
            err   <= 1'b1;
            state <= S_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pbit_fetch_loader_chk.sv
module pbit_fetch_loader_chk #(
  parameter int AW    = 32,
  parameter int TILES = 9,
  parameter int TW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          full_mode,
  input logic [TW-1:0] tile_sel,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic          cfg_sel,
  input logic          cfg_wr,
  input logic          busy,
  input logic          load_ok,
  input logic          load_err
);

  p_hold_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> !rd_valid || rd_addr == $past(rd_addr) + AW'(1));

  p_wr_in_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> busy);

  p_ok_ends_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_ok) |-> !busy);

  p_err_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_err) |-> !busy);

  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_ok && load_err));

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && (full_mode || 32'(tile_sel) < TILES) |=> busy && !load_ok && !load_err);

  p_bad_tile_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && !full_mode && 32'(tile_sel) >= TILES |=> !busy);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_valid && !cfg_sel && !cfg_wr);

endmodule

bind pbit_fetch_loader pbit_fetch_loader_chk #(.AW(AW), .TILES(TILES), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .full_mode(full_mode), .tile_sel(tile_sel),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .cfg_sel(cfg_sel),
  .cfg_wr(cfg_wr), .busy(busy), .load_ok(load_ok), .load_err(load_err));

// File: tb/pbit_fetch_loader_test.sv
module pbit_fetch_loader_test;
  localparam int TOUT = 6;

  logic clk = 0;
  always #2 clk = ~clk;

  logic rst_n = 0, start = 0, full_mode = 0, bad_set = 0, cfg_done = 0;
  logic [3:0]  tile_sel = 0;
  logic [7:0]  done_timeout = 8'(TOUT);
  logic rd_ready = 0, rsp_valid = 0;
  logic [7:0]  rsp_data = 0;
  logic rd_valid, cfg_sel, cfg_wr, busy, load_ok, load_err;
  logic [31:0] rd_addr;
  logic [7:0]  cfg_data;

  pbit_fetch_loader #(
    .AW(32), .LW(32), .TILES(9), .TOW(8),
    .FULL_BASE(32'h400), .FULL_LEN(32'd20),
    .GOOD_BASE({32'h8040, 32'h7040, 32'h6040, 32'h5040, 32'h4040,
                32'h3040, 32'h2040, 32'h1040, 32'h0040}),
    .GOOD_LEN({32'd12, 32'd11, 32'd10, 32'd9, 32'd8, 32'd7, 32'd6, 32'd5, 32'd4}),
    .BAD_BASE({32'h20807, 32'h20707, 32'h20607, 32'h20507, 32'h20407,
               32'h20307, 32'h20207, 32'h20107, 32'h20007}),
    .BAD_LEN({32'd11, 32'd10, 32'd9, 32'd8, 32'd7, 32'd6, 32'd5, 32'd4, 32'd3})
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .full_mode(full_mode), .bad_set(bad_set),
    .tile_sel(tile_sel), .done_timeout(done_timeout), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .rd_ready(rd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_data(cfg_data), .cfg_done(cfg_done),
    .busy(busy), .load_ok(load_ok), .load_err(load_err));

  function automatic logic [31:0] img_base(bit full, bit bad, int k);
    if (full) return 32'h400;
    return bad ? 32'h20007 + 32'h100 * k : 32'h40 + 32'h1000 * k;
  endfunction
  function automatic int img_len(bit full, bit bad, int k);
    if (full) return 20;
    return bad ? 3 + k : 4 + k;
  endfunction
  function automatic logic [7:0] byte_of(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  int checks = 0, fails = 0, cyc = 0;
  int m_state = 0, m_req = 0, m_rsp = 0, m_tmr = 0, wr_count = 0;
  logic [31:0] m_addr = 0, m_rspaddr = 0, first_addr = 0;
  bit m_ok = 0, m_err = 0, m_doneq = 0, first_seen = 0;
  logic [31:0] q[$];
  logic [15:0] lfsr = 16'hACE1;
  bit stall_mode = 1;

  task automatic chk(bit cond, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // storage stimulus
  always @(negedge clk) begin
    lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_ready  = stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
    rsp_valid = (q.size() > 0) && (stall_mode ? (lfsr[1] | lfsr[5]) : 1'b1);
    rsp_data  = rsp_valid ? byte_of(q[0]) : 8'h00;
  end

  // reference model
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      m_state = 0; m_ok = 0; m_err = 0; m_doneq = 0; q.delete();
    end else begin
      case (m_state)
        0: if (start && (full_mode || tile_sel < 9)) begin
          m_addr = img_base(full_mode, bad_set, int'(tile_sel));
          m_req = img_len(full_mode, bad_set, int'(tile_sel));
          m_rsp = m_req; m_rspaddr = m_addr; m_tmr = 0;
          m_ok = 0; m_err = 0; wr_count = 0; first_seen = 0;
          m_state = (m_req == 0) ? 2 : 1;
        end
        1: begin
          if (m_req != 0 && rd_ready) begin
            q.push_back(m_addr); m_addr++; m_req--;
          end
          if (rsp_valid) begin
            void'(q.pop_front()); m_rspaddr++; m_rsp--;
            if (m_rsp == 0) begin m_state = 2; m_tmr = 0; end
          end
        end
        default: begin
          if (cfg_done != m_doneq) begin m_ok = 1; m_state = 0; end
          else if (m_tmr == TOUT) begin m_err = 1; m_state = 0; end
          else m_tmr++;
        end
      endcase
      m_doneq = cfg_done;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk(busy == (m_state != 0), "R9 busy", busy, m_state != 0);
      chk(rd_valid == (m_state == 1 && m_req != 0), "R4 rd_valid", rd_valid, m_state == 1 && m_req != 0);
      if (rd_valid && m_state == 1) chk(rd_addr == m_addr, "R4 rd_addr", rd_addr, m_addr);
      chk(cfg_sel == (m_state == 1), "R5 cfg_sel", cfg_sel, m_state == 1);
      chk(cfg_wr == (m_state == 1 && rsp_valid), "R5 cfg_wr", cfg_wr, m_state == 1 && rsp_valid);
      if (cfg_wr) begin
        chk(cfg_data == byte_of(m_rspaddr), "R5 cfg_data", cfg_data, byte_of(m_rspaddr));
        wr_count++;
      end
      if (rd_valid && !first_seen) begin first_addr = rd_addr; first_seen = 1; end
      chk(load_ok == m_ok, "R6 load_ok", load_ok, m_ok);
      chk(load_err == m_err, "R7 load_err", load_err, m_err);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // d < 0: no done change; mid: start and done change during transfer
  task automatic run_load(bit full, bit bad, int k, int d, bit mid, bit exp_ok, string tag);
    logic [31:0] base = img_base(full, bad, k);
    int len = img_len(full, bad, k);
    @(negedge clk);
    full_mode = full; bad_set = bad; tile_sel = 4'(k); start = 1;
    @(negedge clk);
    start = 0;
    if (mid) begin
      @(negedge clk);
      chk(m_state == 1, "R11 still transferring", m_state, 1);
      start = 1; tile_sel = 4'd5; full_mode = 0; bad_set = 0; cfg_done = ~cfg_done;
      @(negedge clk);
      start = 0;
    end
    while (m_state != 2) @(negedge clk);
    if (d >= 0) begin
      repeat (d) @(negedge clk);
      cfg_done = ~cfg_done;
    end
    while (m_state != 0) @(negedge clk);
    #2;
    chk(load_ok == exp_ok, {tag, " outcome ok"}, load_ok, exp_ok);
    chk(load_err == !exp_ok, {tag, " outcome err"}, load_err, !exp_ok);
    chk(wr_count == len, {tag, " byte count"}, wr_count, len);
    chk(first_addr == base, {tag, " first address"}, first_addr, base);
    chk(!busy, {tag, " busy low at end"}, busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !rd_valid && !cfg_sel && !cfg_wr, "R12 reset outputs", {busy, rd_valid, cfg_sel, cfg_wr}, 0);
    chk(!load_ok && !load_err, "R12 reset flags", {load_ok, load_err}, 0);
    @(negedge clk);
    rst_n = 1;
    run_load(0, 0, 0, 2, 0, 1, "R1 intact tile0");
    run_load(0, 0, 8, 0, 0, 1, "R1 intact tile8 R6 fall");
    run_load(0, 1, 3, 1, 0, 1, "R2 corrupt tile3");
    stall_mode = 0;
    run_load(0, 1, 8, 3, 0, 1, "R2 corrupt tile8 full speed");
    run_load(1, 1, 12, 4, 0, 1, "R3 full image");
    stall_mode = 1;
    run_load(0, 0, 2, TOUT + 1, 0, 0, "R7 late change");
    run_load(0, 0, 4, -1, 0, 0, "R7 no change");
    run_load(0, 0, 6, TOUT, 0, 1, "R8 last window cycle");
    run_load(0, 0, 7, -1, 1, 0, "R10 R11 mid start and change");
    // out-of-range tile start
    @(negedge clk);
    full_mode = 0; tile_sel = 4'd9; start = 1;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    #2;
    chk(!busy, "R10 tile 9 ignored busy", busy, 0);
    chk(load_err && !load_ok, "R10 tile 9 flags held", {load_ok, load_err}, 2'b01);
    run_load(0, 0, 1, 0, 0, 1, "R9 flags cleared on start");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule